// File: doc/BRIEF.md
# Retriggerable Read-Clock Strobe Generator

This block produces the active-low read clock that a host microcontroller uses to pick up decoded bits from a two-track stripe decoder. Each channel watches a one-cycle "bit detected" event from its decoder. When the event arrives, the channel pulses a data-latch enable so that the output bit register takes the new value. It then waits a fixed lead-in of microsecond ticks and pulls its read clock low for a programmable number of ticks.

The fixed lead-in means the data is stable well before the falling edge. Data also stays valid after that edge, until the next bit event, which comes at least one lead-in before the next falling edge. If a new bit is detected while the clock is still low, the clock returns high at once and a fresh cycle starts.

Timing is counted in ticks of a shared enable input, normally one per microsecond. The low width is a digital setting per channel. It is clamped into a legal band. Channels share nothing except the clock, the reset and the tick.

Top module: `rdclk_strobe_gen`

## Requirements
- R1: While rst_ni is low, every rd_clk_no bit is 1 and every data_le_o bit is 0, and bit events are ignored.
- R2: After a bit event on a channel, its rd_clk_no falls on the clock edge that counts the LEAD_TICKS-th (default 12) tick after the event, and not earlier.
- R3: Once low, rd_clk_no stays low for exactly the clamped width in ticks, then returns to 1 and stays 1 until the next event.
- R4: A width setting below MIN_W (default 14) gives a low time of MIN_W ticks.
- R5: A width setting above MAX_W (default 60) gives a low time of MAX_W ticks.
- R6: A bit event while rd_clk_no is low drives rd_clk_no to 1 on the next edge and starts a full new lead-in.
- R7: A bit event during the lead-in restarts the lead-in count from zero.
- R8: data_le_o of a channel is 1 for exactly the one cycle after each bit event on that channel, and 0 otherwise.
- R9: An event on one channel leaves the other channel's rd_clk_no and data_le_o unchanged.
- R10: The width is captured at the bit event. Later changes to width_i do not alter the pulse already in progress.
- R11: Lead-in and low counts advance only on cycles with tick_i high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time-base enable, one cycle per microsecond |
| bit_evt_i | input | NUM_CH | One-cycle bit-detected event per channel |
| width_i | input | NUM_CH*WW | Low-time setting per channel in ticks; channel c uses bits [c*WW +: WW] |
| rd_clk_no | output | NUM_CH | Active-low read clock per channel |
| data_le_o | output | NUM_CH | Data-latch enable per channel |

## Verification
The latch enable is due in the cycle right after the event edge. With tick_i held high, the falling edge of the read clock comes LEAD_TICKS edges after the event and the rising edge comes W edges after that. The directed tasks drive inputs on falling clock edges and sample on each later falling edge. They count the high and low cycles from the event, and those counts are compared with 12 and with the clamped width. In the slow-tick scenario the ticks arrive every fourth cycle, so the counts are checked against a window of plus or minus three cycles around the tick multiple.

// File: rtl/rdclk_pkg.sv
package rdclk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_LOW  = 2'd2
    } rc_state_e;
endpackage

// File: rtl/rdclk_width_clamp.sv
module rdclk_width_clamp #(
    parameter int WW    = 6,
    parameter int MIN_W = 14,
    parameter int MAX_W = 60
) (
    input  logic [WW-1:0] raw_i,
    output logic [WW-1:0] clamped_o
);
    localparam logic [WW-1:0] LO_V = WW'(MIN_W);
    localparam logic [WW-1:0] HI_V = WW'(MAX_W);

    always_comb begin
        if (raw_i < LO_V)      clamped_o = LO_V;
        else if (raw_i > HI_V) clamped_o = HI_V;
        else                   clamped_o = raw_i;
    end
endmodule

// File: rtl/rdclk_chan.sv
module rdclk_chan
    import rdclk_pkg::*;
#(
    parameter int WW         = 6,
    parameter int LEAD_TICKS = 12,
    parameter int MIN_W      = 14,
    parameter int MAX_W      = 60
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic          bit_evt_i,
    input  logic [WW-1:0] width_i,
    output logic          rd_clk_no,
    output logic          data_le_o
);
    localparam int CNT_MAX = (LEAD_TICKS > MAX_W) ? LEAD_TICKS : MAX_W;
    localparam int CW      = $clog2(CNT_MAX + 1);

    typedef struct packed {
        rc_state_e     state;
        logic [CW-1:0] cnt;
        logic [WW-1:0] width;
        logic          clk_n;
        logic          le;
    } chan_reg_t;

    chan_reg_t r_d, r_q;
    logic [WW-1:0] width_clamped;
    logic [CW:0]   cnt_nxt;

    rdclk_width_clamp #(.WW(WW), .MIN_W(MIN_W), .MAX_W(MAX_W)) u_clamp (
        .raw_i     (width_i),
        .clamped_o (width_clamped)
    );

    assign cnt_nxt = {1'b0, r_q.cnt} + 1'b1;

    always_comb begin
        r_d    = r_q;
        r_d.le = 1'b0;
        if (bit_evt_i) begin
            r_d.state = ST_LEAD;
            r_d.cnt   = '0;
            r_d.width = width_clamped;
            r_d.clk_n = 1'b1;
            r_d.le    = 1'b1;
        end else begin
            case (r_q.state)
                ST_LEAD: if (tick_i) begin
                    if (cnt_nxt == (CW+1)'(LEAD_TICKS)) begin
                        r_d.state = ST_LOW;
                        r_d.cnt   = '0;
                        r_d.clk_n = 1'b0;
                    end else begin
                        r_d.cnt = cnt_nxt[CW-1:0];
                    end
                end
                ST_LOW: if (tick_i) begin
                    if (cnt_nxt == (CW+1)'(r_q.width)) begin
                        r_d.state = ST_IDLE;
                        r_d.cnt   = '0;
                        r_d.clk_n = 1'b1;
                    end else begin
                        r_d.cnt = cnt_nxt[CW-1:0];
                    end
                end
                default: begin
                    r_d.state = ST_IDLE;
                    r_d.clk_n = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.state <= ST_IDLE;
            r_q.cnt   <= '0;
            r_q.width <= WW'(MIN_W);
            r_q.clk_n <= 1'b1;
            r_q.le    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_clk_no = r_q.clk_n;
    assign data_le_o = r_q.le;

    // R6
    early_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bit_evt_i && !rd_clk_no) |=> rd_clk_no);

    // R8
    latch_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bit_evt_i |=> data_le_o);

    // R8
    latch_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (data_le_o && $past(rst_ni)) |-> $past(bit_evt_i));

    // R2
    fall_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(rd_clk_no) |-> ($past(tick_i) && !$past(bit_evt_i)));

    // R4
    width_band_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.state == ST_LOW) |-> (r_q.width >= WW'(MIN_W) && r_q.width <= WW'(MAX_W)));
endmodule

// File: rtl/rdclk_strobe_gen.sv
module rdclk_strobe_gen #(
    parameter int NUM_CH     = 2,
    parameter int WW         = 6,
    parameter int LEAD_TICKS = 12,
    parameter int MIN_W      = 14,
    parameter int MAX_W      = 60
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 tick_i,
    input  logic [NUM_CH-1:0]    bit_evt_i,
    input  logic [NUM_CH*WW-1:0] width_i,
    output logic [NUM_CH-1:0]    rd_clk_no,
    output logic [NUM_CH-1:0]    data_le_o
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        rdclk_chan #(
            .WW(WW), .LEAD_TICKS(LEAD_TICKS), .MIN_W(MIN_W), .MAX_W(MAX_W)
        ) u_chan (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .tick_i    (tick_i),
            .bit_evt_i (bit_evt_i[c]),
            .width_i   (width_i[c*WW +: WW]),
            .rd_clk_no (rd_clk_no[c]),
            .data_le_o (data_le_o[c])
        );
    end
endmodule

// File: tb/rdclk_strobe_gen_bench.sv
`timescale 1ns/1ps
module rdclk_strobe_gen_bench;
    localparam int WW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b1;
    logic [1:0]    evt = '0;
    logic [WW-1:0] wset0 = 6'd20;
    logic [WW-1:0] wset1 = 6'd20;
    logic [1:0]    rd_clk_n;
    logic [1:0]    le;
    logic          slow = 1'b0;
    int            tdiv = 0;
    int            n_chk = 0;
    int            n_fail = 0;
    bit            done = 1'b0;

    always #4 clk = ~clk;

    rdclk_strobe_gen u_rdclk_strobe_gen (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .bit_evt_i(evt),
        .width_i({wset1, wset0}), .rd_clk_no(rd_clk_n), .data_le_o(le)
    );

    initial forever begin
        @(negedge clk);
        tdiv = (tdiv + 1) % 4;
        tick = slow ? (tdiv == 0) : 1'b1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_w(input int ch, input int w);
        if (ch == 0) wset0 = WW'(w); else wset1 = WW'(w);
    endtask

    // fires an event and measures high (lead-in) and low cycle counts
    task automatic fire_measure(input int ch, output int hi, output int lo, output bit le_ok);
        @(negedge clk);
        evt[ch] = 1'b1;
        @(negedge clk);
        evt[ch] = 1'b0;
        le_ok = le[ch];
        hi = 0;
        while (rd_clk_n[ch] && hi < 400) begin hi++; @(negedge clk); end
        lo = 0;
        while (!rd_clk_n[ch] && lo < 400) begin lo++; @(negedge clk); end
    endtask

    task automatic t_reset;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            evt = (i == 3) ? 2'b11 : 2'b00;
        end
        @(negedge clk);
        evt = '0;
        chk(rd_clk_n == 2'b11, "R1 clk idle", rd_clk_n, 3);
        chk(le == 2'b00, "R1 le idle", le, 0);
        rst_n = 1'b1;
        repeat (30) @(negedge clk);
        chk(rd_clk_n == 2'b11, "R1 no pulse from reset-time event", rd_clk_n, 3);
    endtask

    task automatic t_basic(input int w, input int exp_lo, input string req);
        int hi, lo; bit lok;
        set_w(0, w);
        fire_measure(0, hi, lo, lok);
        chk(lok, "R8 latch enable after event", lok, 1);
        chk(hi == 12, "R2 lead-in cycles", hi, 12);
        chk(lo == exp_lo, req, lo, exp_lo);
        chk(le[0] == 1'b0, "R8 latch enable single cycle", le[0], 0);
        repeat (5) @(negedge clk);
        chk(rd_clk_n[0], "R3 stays high after pulse", rd_clk_n[0], 1);
    endtask

    task automatic t_early_release;
        int hi, lo; bit lok;
        set_w(0, 60);
        @(negedge clk); evt[0] = 1'b1;
        @(negedge clk); evt[0] = 1'b0;
        repeat (16) @(negedge clk);
        chk(!rd_clk_n[0], "R6 low before retrigger", rd_clk_n[0], 0);
        set_w(0, 25);
        fire_measure(0, hi, lo, lok);
        chk(hi == 12, "R6 high at once then full lead-in", hi, 12);
        chk(lo == 25, "R6 new low width", lo, 25);
    endtask

    task automatic t_lead_restart;
        int hi, lo; bit lok;
        set_w(0, 16);
        @(negedge clk); evt[0] = 1'b1;
        @(negedge clk); evt[0] = 1'b0;
        repeat (6) @(negedge clk);
        fire_measure(0, hi, lo, lok);
        chk(hi == 12, "R7 lead-in restarted", hi, 12);
        chk(lo == 16, "R7 width after restart", lo, 16);
    endtask

    task automatic t_width_capture;
        int lo; bit saw_le1;
        set_w(0, 20);
        @(negedge clk); evt[0] = 1'b1;
        @(negedge clk); evt[0] = 1'b0;
        set_w(0, 50);
        saw_le1 = 1'b0;
        while (rd_clk_n[0]) begin
            if (le[1] || !rd_clk_n[1]) saw_le1 = 1'b1;
            @(negedge clk);
        end
        lo = 0;
        while (!rd_clk_n[0] && lo < 400) begin
            if (le[1] || !rd_clk_n[1]) saw_le1 = 1'b1;
            lo++; @(negedge clk);
        end
        chk(lo == 20, "R10 width captured at event", lo, 20);
        chk(!saw_le1, "R9 other channel untouched", saw_le1, 0);
    endtask

    task automatic t_ch1;
        int hi, lo; bit lok;
        set_w(1, 33);
        fire_measure(1, hi, lo, lok);
        chk(lok && hi == 12, "R9 channel 1 lead-in", hi, 12);
        chk(lo == 33, "R9 channel 1 width", lo, 33);
        chk(rd_clk_n[0], "R9 channel 0 idle", rd_clk_n[0], 1);
    endtask

    task automatic t_slow_tick;
        int hi, lo; bit lok;
        slow = 1'b1;
        set_w(0, 14);
        fire_measure(0, hi, lo, lok);
        chk(hi >= 45 && hi <= 51, "R11 lead-in on slow tick", hi, 48);
        chk(lo >= 53 && lo <= 59, "R11 low on slow tick", lo, 56);
        slow = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_basic(20, 20, "R3 low width");
        t_basic(3, 14, "R4 clamp to minimum");
        t_basic(63, 60, "R5 clamp to maximum");
        t_basic(14, 14, "R3 width at minimum");
        t_early_release();
        t_lead_restart();
        t_width_capture();
        t_ch1();
        t_slow_tick();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule